// File: doc/BRIEF.md
# Serial PHY Management Master

This block issues single management transactions to an Ethernet PHY over the two-wire management interface, MDC and MDIO. The host logic sets a 5-bit register number and a read/write flag, adds 16 bits of data for a write, and pulses `start` while the block is idle. The block then generates the management clock from the system clock and shifts out a complete frame. For a read, it releases the data line and captures the PHY's reply.

The PHY address is fixed by a parameter, and so is the ratio of system clock to management clock. Each frame opens with a long run of ones as its preamble. A write frame lasts 66 management clock periods. A read frame lasts 65, because only one period is spent on turnaround. The data line is split into an output, an output enable and an input, and the pad logic outside the block combines them.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is asserted and after reset is released, `busy`, `mdc`, `mdio_oe`, `rdata_valid` are 0, `rdata` is 0 and `mdio_o` is 1.
- R2: A `start` seen while idle is accepted, and `busy` is 1 in the next cycle. It stays 1 until the last bit period of the frame has ended.
- R3: One management clock period is `CLK_DIV` system cycles: the first half has `mdc` low and the second half has `mdc` high. A write frame has 66 such periods and a read frame has 65, so `busy` stays high for 66·`CLK_DIV` or 65·`CLK_DIV` cycles.
- R4: Bit periods 0 to 33 of every frame carry a 1 on `mdio_o`.
- R5: Bit 34 is 0 and bit 35 is 1. Bits 36 and 37 are 1,0 for a read and 0,1 for a write.
- R6: Bits 38 to 42 carry `PHY_ADDR` MSB first. Bits 43 to 47 carry `reg_addr` MSB first.
- R7: In a write, bits 48 and 49 are 1 then 0 and bits 50 to 65 carry `wdata` MSB first. `mdio_oe` is 1 throughout the frame.
- R8: In a read, `mdio_oe` is 1 for bits 0 to 47 and 0 from bit 48 to the end of the frame. Bit 48 is not captured. The values on `mdio_i` in bits 49 to 64 become `rdata[15:0]` MSB first.
- R9: `mdio_o` changes only while `mdc` is low and holds its level across every high phase.
- R10: `mdio_i` is sampled only during the high phase of `mdc`. Its level during low phases does not affect `rdata`.
- R11: `rdata_valid` is a one-cycle pulse in the cycle `busy` falls, and only at the end of a read. `rdata` changes only with that pulse, so a write leaves it unchanged.
- R12: A `start` raised while `busy` is 1 is ignored. The frame in progress is unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transaction (taken when idle) |
| is_write | input | 1 | 1 selects a write, 0 a read |
| reg_addr | input | 5 | PHY register number |
| wdata | input | 16 | Data for a write |
| busy | output | 1 | A frame is in progress |
| rdata | output | 16 | Data from the last completed read |
| rdata_valid | output | 1 | One-cycle pulse when a read completes |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output level |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input level |

## Verification
The bench builds the block with `CLK_DIV` = 4, the smallest even ratio, so a frame takes about 260 cycles and every phase boundary falls on adjacent edges. It sets `PHY_ADDR` to 5'h12, whose asymmetric bit pattern makes a reversed or shifted address field visible, unlike the default of 1. A PHY model drives reply bits during the high phase and inverted junk during the low phase, so a sample taken in the wrong phase corrupts `rdata`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PREAMBLE_BITS = 34;
  localparam int unsigned ADDR_W        = 5;
  localparam int unsigned DATA_W        = 16;
  // start(2) + opcode(2) + phy(5) + reg(5) + turnaround(2) + data(16)
  localparam int unsigned HDR_BITS      = 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int unsigned WR_FRAME_BITS = PREAMBLE_BITS + HDR_BITS;
  localparam int unsigned RD_FRAME_BITS = WR_FRAME_BITS - 1;
  localparam int unsigned TA_FIRST_BIT  = PREAMBLE_BITS + 4 + 2 * ADDR_W;
  localparam int unsigned RD_FIRST_BIT  = TA_FIRST_BIT + 1;
  localparam int unsigned BIT_IDX_W     = $clog2(WR_FRAME_BITS);

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OPC_RD  = 2'b10;
  localparam logic [1:0] OPC_WR  = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
  localparam logic [1:0] TA_RD   = 2'b11;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Divides the system clock into management clock periods:
// low for the first half, high for the second half.
module mdio_mdc_gen #(
  parameter int unsigned CLK_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_end,
  output logic sample_tick
);
  localparam int unsigned CNT_W  = $clog2(CLK_DIV);
  localparam int unsigned HALF   = CLK_DIV / 2;
  localparam int unsigned SAMPLE = HALF + HALF / 2 - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  assign bit_end     = run && (cnt_q == CNT_W'(CLK_DIV - 1));
  assign sample_tick = run && (cnt_q == CNT_W'(SAMPLE));
  assign mdc         = mdc_q;

  always_comb begin
    if (!run || bit_end) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
    // registered clock: high exactly while the counter sits in the upper half
    mdc_d = run && !bit_end && (cnt_d >= CNT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_bit_counter.sv
// Counts bit periods within a frame.
module mdio_bit_counter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  output logic [W-1:0] bit_idx
);
  logic [W-1:0] idx_q, idx_d;

  always_comb begin
    if (clear)        idx_d = '0;
    else if (advance) idx_d = idx_q + W'(1);
    else              idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign bit_idx = idx_q;
endmodule

// File: rtl/mdio_tx_shifter.sv
// Holds the post-preamble part of a frame and presents it MSB first.
module mdio_tx_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    if (load)       sr_d = load_word;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b1};
    else            sr_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter int unsigned CLK_DIV  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic [15:0] rdata,
  output logic        rdata_valid,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic                 valid_q, valid_d;
  logic                 accept, finish, last_bit, in_preamble;
  logic                 bit_end, sample_tick, tx_msb, rx_en, tx_shift;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [HDR_BITS-1:0]  hdr_word;

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .mdc(mdc), .bit_end(bit_end), .sample_tick(sample_tick)
  );

  mdio_bit_counter #(.W(BIT_IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .advance(busy_q && bit_end), .bit_idx(bit_idx)
  );

  assign hdr_word = {SOF_PAT,
                     is_write ? OPC_WR : OPC_RD,
                     PHY_ADDR,
                     reg_addr,
                     is_write ? TA_WR : TA_RD,
                     is_write ? wdata : {DATA_W{1'b1}}};

  mdio_tx_shifter #(.W(HDR_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(hdr_word),
    .shift(tx_shift), .msb(tx_msb)
  );

  always_comb begin
    accept      = start && !busy_q;
    in_preamble = bit_idx < BIT_IDX_W'(PREAMBLE_BITS);
    last_bit    = rd_q ? (bit_idx == BIT_IDX_W'(RD_FRAME_BITS - 1))
                       : (bit_idx == BIT_IDX_W'(WR_FRAME_BITS - 1));
    finish      = busy_q && bit_end && last_bit;
    tx_shift    = busy_q && bit_end && !in_preamble;
    rx_en       = busy_q && rd_q && sample_tick &&
                  (bit_idx >= BIT_IDX_W'(RD_FIRST_BIT));

    busy_d  = accept ? 1'b1 : (finish ? 1'b0 : busy_q);
    rd_d    = accept ? !is_write : rd_q;
    rx_d    = rx_en ? {rx_q[DATA_W-2:0], mdio_i} : rx_q;
    rdata_d = (finish && rd_q) ? rx_q : rdata_q;
    valid_d = finish && rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      rx_q    <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
      valid_q <= valid_d;
    end
  end

  assign busy        = busy_q;
  assign rdata       = rdata_q;
  assign rdata_valid = valid_q;
  assign mdio_o      = (!busy_q || in_preamble) ? 1'b1 : tx_msb;
  assign mdio_oe     = busy_q && !(rd_q && (bit_idx >= BIT_IDX_W'(TA_FIRST_BIT)));
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rdata,
  input logic        rdata_valid
);
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_level_held_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  p_valid_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  p_valid_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> (!busy && $past(busy)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> rdata_valid);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata), .rdata_valid(rdata_valid)
);

// File: tb/mdio_frame_master_tb_top.sv
module mdio_frame_master_tb_top;
  localparam int         DIV = 4;
  localparam logic [4:0] PHY = 5'h12;
  localparam int         NV  = 6;
  // vector: {is_write, reg_addr, wdata, phy reply}
  localparam logic [37:0] VEC [0:NV-1] = '{
    {1'b1, 5'h00, 16'h0000, 16'h0000},
    {1'b0, 5'h01, 16'h0000, 16'h796D},
    {1'b1, 5'h1F, 16'hA5C3, 16'h0000},
    {1'b0, 5'h10, 16'h0000, 16'h8001},
    {1'b1, 5'h15, 16'hFFFF, 16'h0000},
    {1'b0, 5'h19, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n, start, is_write, mdio_i;
  logic [4:0]  reg_addr;
  logic [15:0] wdata, rdata;
  logic busy, rdata_valid, mdc, mdio_o, mdio_oe;

  always #4 clk = ~clk;

  mdio_frame_master #(.PHY_ADDR(PHY), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .reg_addr(reg_addr), .wdata(wdata), .busy(busy), .rdata(rdata),
    .rdata_valid(rdata_valid), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_checks = 0, n_fail = 0;
  logic bits_o [0:79];
  logic bits_oe[0:79];
  int rise_cnt = 0, unstable = 0, hi_cyc = 0, busy_cyc = 0, valid_cnt = 0;
  logic [15:0] resp_q = 16'h0;
  logic [15:0] last_rd = 16'h0;
  logic prev_mdc = 1'b0, prev_o = 1'b1;

  // PHY model: reply bit during the high phase, junk during the low phase
  always @(posedge mdc) begin
    #1;
    if (rise_cnt < 80) begin
      bits_o[rise_cnt]  = mdio_o;
      bits_oe[rise_cnt] = mdio_oe;
    end
    if (rise_cnt >= 49 && rise_cnt <= 64) mdio_i = resp_q[64 - rise_cnt];
    rise_cnt++;
  end
  always @(negedge mdc) begin
    #1;
    mdio_i = ~mdio_i;
  end

  always @(negedge clk) begin
    if (mdc && prev_mdc && (mdio_o !== prev_o)) unstable++;
    if (mdc) hi_cyc++;
    if (busy) busy_cyc++;
    if (rdata_valid) valid_cnt++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic w,
                                   input logic [4:0] ra, input logic [15:0] d);
    if (k < 34)  return 1'b1;
    if (k == 34) return 1'b0;
    if (k == 35) return 1'b1;
    if (k == 36) return !w;
    if (k == 37) return w;
    if (k <= 42) return PHY[42 - k];
    if (k <= 47) return ra[47 - k];
    if (k == 48) return 1'b1;
    if (k == 49) return 1'b0;
    return d[65 - k];
  endfunction

  task automatic seg(input string req, input int lo, input int hi, input logic w,
                     input logic [4:0] ra, input logic [15:0] d);
    int bad = 0;
    for (int k = lo; k <= hi; k++)
      if (bits_o[k] !== exp_bit(k, w, ra, d)) bad++;
    check(bad == 0, req, $sformatf("mdio_o bits %0d..%0d mismatches", lo, hi), bad, 0);
  endtask

  task automatic show_reset(input string tag);
    check(busy == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0 && rdata_valid == 1'b0,
          "R1", {tag, " control outputs"}, {busy, mdc, mdio_oe, rdata_valid}, 0);
    check(rdata == 16'h0 && mdio_o == 1'b1, "R1", {tag, " rdata/mdio_o"},
          {rdata, mdio_o}, 1);
  endtask

  task automatic run_frame(input logic w, input logic [4:0] ra, input logic [15:0] d,
                           input logic [15:0] resp, input bit poke_busy);
    int nb;
    int rises_at_end;
    nb = w ? 66 : 65;
    @(posedge clk); #2;
    rise_cnt = 0; unstable = 0; hi_cyc = 0; busy_cyc = 0; valid_cnt = 0;
    resp_q = resp; is_write = w; reg_addr = ra; wdata = d; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
    if (poke_busy) begin
      repeat (20) @(posedge clk);
      #2; start = 1'b1; is_write = ~w; reg_addr = 5'h0A; wdata = 16'h1234;
      @(posedge clk); #2; start = 1'b0;
    end
    while (busy === 1'b1) begin
      @(posedge clk); #2;
    end
    repeat (3) @(posedge clk);
    #2;
    check(rise_cnt == nb, "R3", "mdc periods per frame", rise_cnt, nb);
    check(busy_cyc == nb * DIV, "R3", "busy cycles", busy_cyc, nb * DIV);
    check(hi_cyc == nb * DIV / 2, "R3", "mdc high cycles", hi_cyc, nb * DIV / 2);
    seg("R4", 0, 33, w, ra, d);
    seg("R5", 34, 37, w, ra, d);
    seg("R6", 38, 47, w, ra, d);
    check(unstable == 0, "R9", "mdio_o changes in high phase", unstable, 0);
    if (w) begin
      int oe_bad = 0;
      seg("R7", 48, 65, w, ra, d);
      for (int k = 0; k < 66; k++) if (bits_oe[k] !== 1'b1) oe_bad++;
      check(oe_bad == 0, "R7", "write oe low periods", oe_bad, 0);
      check(valid_cnt == 0, "R11", "rdata_valid on write", valid_cnt, 0);
      check(rdata == last_rd, "R11", "rdata after write", rdata, last_rd);
    end else begin
      int oe_bad = 0;
      for (int k = 0; k < 65; k++) if (bits_oe[k] !== (k < 48)) oe_bad++;
      check(oe_bad == 0, "R8", "read oe pattern", oe_bad, 0);
      check(rdata == resp, "R8/R10", "captured rdata", rdata, resp);
      check(valid_cnt == 1, "R11", "rdata_valid pulses", valid_cnt, 1);
      last_rd = resp;
    end
    if (poke_busy) begin
      rises_at_end = rise_cnt;
      repeat (12) @(posedge clk);
      #2;
      check(busy == 1'b0 && rise_cnt == rises_at_end, "R12",
            "frame after ignored start", rise_cnt, rises_at_end);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_write = 1'b0; reg_addr = '0; wdata = '0;
    mdio_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    show_reset("during reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    show_reset("after release");

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][37], VEC[v][36:32], VEC[v][31:16], VEC[v][15:0], 1'b0);

    // R12: start raised in the middle of a write and of a read
    run_frame(1'b1, 5'h0C, 16'h3C96, 16'h0, 1'b1);
    run_frame(1'b0, 5'h07, 16'h0, 16'h5AA5, 1'b1);

    // R2/R11: new start in the very cycle rdata_valid pulses is accepted
    @(posedge clk); #2;
    resp_q = 16'h1357; is_write = 1'b0; reg_addr = 5'h03; start = 1'b1; rise_cnt = 0;
    @(posedge clk); #2; start = 1'b0;
    while (busy === 1'b1) begin
      @(posedge clk); #2;
    end
    check(rdata_valid == 1'b1 && rdata == 16'h1357, "R11", "valid with busy fall",
          {rdata_valid, rdata}, {1'b1, 16'h1357});
    last_rd = 16'h1357;
    start = 1'b1; is_write = 1'b1; reg_addr = 5'h04; wdata = 16'h0F0F;
    @(posedge clk); #2; start = 1'b0;
    check(busy == 1'b1, "R2", "back-to-back start accepted", busy, 1);
    while (busy === 1'b1) begin
      @(posedge clk); #2;
    end

    // R1: reset in the middle of a frame
    start = 1'b1; is_write = 1'b1; reg_addr = 5'h02; wdata = 16'hBEEF;
    @(posedge clk); #2; start = 1'b0;
    repeat (30) @(posedge clk);
    #2; rst_n = 1'b0; #1;
    show_reset("mid-frame reset");
    @(posedge clk); #2; rst_n = 1'b1;
    last_rd = 16'h0;
    run_frame(1'b0, 5'h1E, 16'h0, 16'hC3A5, 1'b0);

    finish_run();
  end
endmodule